// File: doc/BRIEF.md
# Four-Word Burst Quad-Rate SRAM Port

This block models one port of a quad-data-rate static memory that moves data in bursts of four words. Reads and writes have separate data buses and share one address bus. The block runs on a fast clock `clk` at twice the memory-cycle rate. The input `kPhase` marks the two kinds of edge: it is high on the main-edge slot and low on the complementary (half-cycle) slot. Requests and addresses are sampled only on main-edge slots. Data is captured or driven on every slot, so one burst of four words takes two memory cycles.

A write captures its four words starting one full cycle after the request. A read drives its first word two and a half cycles after the request, and the other three words follow on the next three slots. Requests of the same kind on consecutive cycles are spaced out: the second one is dropped. The read output has no tristate. It is shown as a valid flag, and the data bus is zero whenever the flag is low. Storage is a small inferred array.

Top module: `qdrb_port`

## Requirements
- R1: While `rstN` is low, and after it is released until a read burst is issued, `rdValid`, `rdData` and `conflict` are all zero.
- R2: Selects and address are sampled only on edges where `kPhase` is 1. A select that is low only on `kPhase`=0 edges starts nothing.
- R3: A write accepted on edge n captures `wrData` on edges n+2, n+3, n+4 and n+5, counted in `clk` edges. Beat i (i=0..3) goes to address {A[ADDR_W-1:2], (A[1:0]+i) mod 4}, so bursts wrap inside their aligned block of four words.
- R4: A read accepted on edge n drives beat i on edge n+5+i, using the same wrapped address order as R3. `rdValid` is high for exactly those four slots, so the first beat appears 2.5 memory cycles after the request.
- R5: A request is ignored, with no effect on memory or outputs, when a request of the same kind was accepted on the previous main edge. A select held low is therefore accepted on every second main edge.
- R6: When both selects are low on a main edge and the read is accepted, the write is dropped and `conflict` is high for the one slot after that edge. A write that meets a read which itself was ignored under R5 goes ahead, and `conflict` stays low.
- R7: Outside read-burst slots `rdValid` is 0 and `rdData` is all zeros. `wrData` presented outside write-capture slots changes no stored word.
- R8: A read beat returns the newest data for its address, including a word captured on the same edge it is read.
- R9: Reads accepted every second main edge produce a gap-free stream of valid beats, and so do writes at that rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, twice the memory-cycle rate |
| rstN | input | 1 | Asynchronous active-low reset |
| kPhase | input | 1 | 1 on main-edge slots, 0 on half-cycle slots |
| rdSelN | input | 1 | Read request, active low |
| wrSelN | input | 1 | Write request, active low |
| addr | input | ADDR_W | Burst start address |
| wrData | input | DATA_W | Write data, one word per slot |
| rdData | output | DATA_W | Read data, zero when not valid |
| rdValid | output | 1 | High on read-burst slots (stands in for a driven bus) |
| conflict | output | 1 | Pulse: a write was dropped in favour of a read |

## Verification
The bench builds the block with ADDR_W=6 and DATA_W=16. That gives 64 words in 16 aligned blocks, so every start offset and every wrap position of a burst can be swept exhaustively in a short run. A slot-by-slot reference schedule, derived from the latencies above, predicts `rdValid`, `rdData` and `conflict` on every slot. This covers spaced, back-to-back, held-low, half-cycle-only and colliding requests, as well as reads that overlap a write burst to the same block.

// File: rtl/qdrb_pkg.sv
package qdrb_pkg;
  localparam int unsigned BURST_LEN    = 4;
  localparam int unsigned BEAT_W       = $clog2(BURST_LEN);
  localparam int unsigned WR_LEAD      = 2;  // slots from request to first captured word
  localparam int unsigned RD_LEAD      = 5;  // slots from request to first driven word

  typedef struct packed {
    logic wrEn;
    logic rdEn;
  } qdrbStrobe_t;
endpackage

// File: rtl/qdrb_burstpipe.sv
module qdrb_burstpipe
  import qdrb_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LEAD   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] startAddr,
  output logic              active,
  output logic [ADDR_W-1:0] beatAddr
);
  localparam int unsigned STAGES = LEAD + BURST_LEN - 1;

  logic [STAGES-1:0] tok;
  logic [ADDR_W-1:0] base [STAGES];
  logic [BURST_LEN-1:0] hit;
  logic [ADDR_W-1:0] addrAt [BURST_LEN];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tok <= '0;
    else       tok <= {tok[STAGES-2:0], start};
  end

  always_ff @(posedge clk) begin
    base[0] <= startAddr;
    for (int s = 1; s < STAGES; s++) base[s] <= base[s-1];
  end

  for (genvar b = 0; b < BURST_LEN; b++) begin : g_tap
    localparam int unsigned TAP = LEAD - 1 + b;
    assign hit[b]    = tok[TAP];
    assign addrAt[b] = {base[TAP][ADDR_W-1:BEAT_W],
                        base[TAP][BEAT_W-1:0] + BEAT_W'(b)};
  end

  always_comb begin
    active   = |hit;
    beatAddr = '0;
    for (int b = 0; b < BURST_LEN; b++)
      if (hit[b]) beatAddr = beatAddr | addrAt[b];
  end
endmodule

// File: rtl/qdrb_ctrl.sv
module qdrb_ctrl
  import qdrb_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              kPhase,
  input  logic              rdSelN,
  input  logic              wrSelN,
  input  logic [ADDR_W-1:0] addr,
  output qdrbStrobe_t       strobe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              conflict
);
  logic rdLast, wrLast;
  logic rdAcc, wrReq, wrAcc;
  logic rdActive, wrActive;

  // same-kind request on the previous main edge makes the select a don't-care
  assign rdAcc = kPhase & ~rdSelN & ~rdLast;
  assign wrReq = kPhase & ~wrSelN & ~wrLast;
  assign wrAcc = wrReq & ~rdAcc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdLast   <= 1'b0;
      wrLast   <= 1'b0;
      conflict <= 1'b0;
    end else begin
      conflict <= wrReq & rdAcc;
      if (kPhase) begin
        rdLast <= rdAcc;
        wrLast <= wrAcc;
      end
    end
  end

  qdrb_burstpipe #(.ADDR_W(ADDR_W), .LEAD(WR_LEAD)) wrPipe (
    .clk(clk), .rstN(rstN), .start(wrAcc), .startAddr(addr),
    .active(wrActive), .beatAddr(wrAddr)
  );

  qdrb_burstpipe #(.ADDR_W(ADDR_W), .LEAD(RD_LEAD)) rdPipe (
    .clk(clk), .rstN(rstN), .start(rdAcc), .startAddr(addr),
    .active(rdActive), .beatAddr(rdAddr)
  );

  assign strobe.wrEn = wrActive;
  assign strobe.rdEn = rdActive;
endmodule

// File: rtl/qdrb_data.sv
module qdrb_data
  import qdrb_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  qdrbStrobe_t       strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdWord;

  always_ff @(posedge clk) begin
    if (strobe.wrEn) mem[wrAddr] <= wrData;
  end

  // a word captured on this very edge is forwarded to the read beat
  assign rdWord = (strobe.wrEn && (wrAddr == rdAddr)) ? wrData : mem[rdAddr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strobe.rdEn;
      rdData  <= strobe.rdEn ? rdWord : '0;
    end
  end
endmodule

// File: rtl/qdrb_port.sv
module qdrb_port
  import qdrb_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              kPhase,
  input  logic              rdSelN,
  input  logic              wrSelN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              conflict
);
  qdrbStrobe_t       strobe;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  qdrb_ctrl #(.ADDR_W(ADDR_W)) ctrl (
    .clk(clk), .rstN(rstN), .kPhase(kPhase), .rdSelN(rdSelN),
    .wrSelN(wrSelN), .addr(addr), .strobe(strobe),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .conflict(conflict)
  );

  qdrb_data #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrAddr(wrAddr),
    .rdAddr(rdAddr), .wrData(wrData), .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: rtl/qdrb_chk.sv
module qdrb_chk #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              kPhase,
  input logic              rdSelN,
  input logic              wrSelN,
  input logic [DATA_W-1:0] rdData,
  input logic              rdValid,
  input logic              conflict
);
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rstN |=> (!rdValid && rdData == '0 && !conflict)); // R1

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> rdData == '0); // R7

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdValid) |-> $past(kPhase && !rdSelN, 6)); // R4

  AST_BURST_FOUR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdValid) |-> rdValid ##1 rdValid ##1 rdValid ##1 rdValid); // R4

  AST_START_HALF: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdValid) |-> kPhase); // R2

  AST_CONFLICT_SRC: assert property (@(posedge clk) disable iff (!rstN)
    conflict |-> $past(kPhase && !rdSelN && !wrSelN)); // R6
endmodule

bind qdrb_port qdrb_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk (
  .clk(clk), .rstN(rstN), .kPhase(kPhase), .rdSelN(rdSelN),
  .wrSelN(wrSelN), .rdData(rdData), .rdValid(rdValid), .conflict(conflict)
);

// File: tb/tb_qdrb_port.sv
module tb_qdrb_port;
  localparam int AW   = 6;
  localparam int DW   = 16;
  localparam int MAXS = 16384;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic kPhase = 1'b1, rdSelN = 1'b1, wrSelN = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic rdValid, conflict;

  qdrb_port #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rstN(rstN), .kPhase(kPhase), .rdSelN(rdSelN),
    .wrSelN(wrSelN), .addr(addr), .wrData(wrData),
    .rdData(rdData), .rdValid(rdValid), .conflict(conflict)
  );

  always #4 clk = ~clk;  // 125 MHz

  int total = 0, bad = 0, n = 0;
  bit finished = 0;
  string tag = "R1";
  logic [DW-1:0] refMem [1<<AW];
  bit schWV [MAXS];
  bit schRV [MAXS];
  logic [AW-1:0] schWA [MAXS];
  logic [AW-1:0] schRA [MAXS];
  bit lastRd = 0, lastWr = 0;
  logic [31:0] lfsr = 32'h1ace_b00c;

  function automatic logic [AW-1:0] beatAddr(logic [AW-1:0] a, int i);
    return {a[AW-1:2], 2'(a[1:0] + 2'(i))};
  endfunction

  task automatic chk(string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s slot=%0d actual=%h expected=%h", tag, what, n, act, exp);
    end
  endtask

  // one clk slot: drive, predict, clock, check
  task automatic step(input logic rdS, input logic wrS, input logic [AW-1:0] a);
    logic [DW-1:0] d;
    bit kr, rdAcc, wrReq, wrAcc, expConf, expV;
    logic [DW-1:0] expD;
    d = DW'(n * 40503 + 4660);
    kr = (n % 2 == 0);
    kPhase = kr; rdSelN = rdS; wrSelN = wrS; addr = a; wrData = d;
    rdAcc = kr && !rdS && !lastRd;
    wrReq = kr && !wrS && !lastWr;
    wrAcc = wrReq && !rdAcc;
    expConf = wrReq && rdAcc;
    if (kr) begin lastRd = rdAcc; lastWr = wrAcc; end
    for (int i = 0; i < 4; i++) begin
      if (rdAcc) begin schRV[n+5+i] = 1; schRA[n+5+i] = beatAddr(a, i); end
      if (wrAcc) begin schWV[n+2+i] = 1; schWA[n+2+i] = beatAddr(a, i); end
    end
    if (schWV[n]) refMem[schWA[n]] = d;
    expV = schRV[n];
    expD = expV ? refMem[schRA[n]] : '0;
    @(posedge clk);
    @(negedge clk);
    chk("rdValid", DW'(rdValid), DW'(expV));
    chk("rdData", rdData, expD);
    chk("conflict", DW'(conflict), DW'(expConf));
    n++;
  endtask

  task automatic kcyc(input logic rdS, input logic wrS, input logic [AW-1:0] a);
    step(rdS, wrS, a);
    step(1'b1, 1'b1, '0);
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) kcyc(1'b1, 1'b1, '0);
  endtask

  initial begin
    for (int i = 0; i < (1<<AW); i++) refMem[i] = '0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("reset rdValid", DW'(rdValid), '0);   // R1
      chk("reset rdData", rdData, '0);           // R1
      chk("reset conflict", DW'(conflict), '0);  // R1
    end
    rstN = 1'b1;
    idle(3);  // R1 after release

    tag = "R3";  // fill with wrapped bursts, write every second cycle (R9)
    for (int b = 0; b < 16; b++) begin
      kcyc(1'b1, 1'b0, AW'(b*4 + b%4));
      kcyc(1'b1, 1'b1, '0);
    end
    idle(4);

    tag = "R4";  // every start address, isolated reads
    for (int a = 0; a < (1<<AW); a++) begin
      kcyc(1'b0, 1'b1, AW'(a));
      idle(3);
    end

    tag = "R9";  // reads every second cycle, gap-free
    for (int i = 0; i < 32; i++) begin
      kcyc(1'b0, 1'b1, AW'(i*2 + 1));
      kcyc(1'b1, 1'b1, '0);
    end
    idle(4);

    tag = "R5";  // held-low selects
    for (int i = 0; i < 10; i++) kcyc(1'b0, 1'b1, AW'(i*5));
    idle(4);
    for (int i = 0; i < 10; i++) kcyc(1'b1, 1'b0, AW'(i*7));
    idle(4);
    for (int i = 0; i < 20; i++) kcyc(1'b0, 1'b1, AW'(i*3));
    idle(4);
    for (int a = 0; a < (1<<AW); a++) begin  // read back after held-low writes
      kcyc(1'b0, 1'b1, AW'(a));
      kcyc(1'b1, 1'b1, '0);
    end
    idle(4);

    tag = "R2";  // selects low only on half-cycle slots
    for (int i = 0; i < 20; i++) begin
      step(1'b1, 1'b1, '0);
      step(1'b0, 1'b0, AW'(i*3));
    end
    idle(2);

    tag = "R6";
    for (int i = 0; i < 8; i++) begin
      kcyc(1'b0, 1'b0, AW'(i*9));
      idle(3);
    end
    for (int i = 0; i < 4; i++) begin  // read ignored by spacing, write proceeds
      kcyc(1'b0, 1'b1, AW'(i*4));
      kcyc(1'b0, 1'b0, AW'(i*4 + 17));
      idle(4);
    end
    for (int a = 0; a < (1<<AW); a += 3) begin kcyc(1'b0, 1'b1, AW'(a)); kcyc(1'b1, 1'b1, '0); end
    idle(4);

    tag = "R8";  // write overlapping a read of the same block
    for (int g = 1; g <= 2; g++)
      for (int off = 0; off < 4; off++) begin
        logic [AW-1:0] base;
        base = AW'(off*13 + g*5);
        kcyc(1'b0, 1'b1, base);
        if (g == 2) kcyc(1'b1, 1'b1, '0);
        kcyc(1'b1, 1'b0, beatAddr(base, off));
        idle(4);
      end

    tag = "R7";  // long NOP with toggling write data, then read back
    idle(40);
    for (int a = 0; a < (1<<AW); a += 4) begin kcyc(1'b0, 1'b1, AW'(a)); kcyc(1'b1, 1'b1, '0); end
    idle(4);

    tag = "R5";  // pseudo-random mix of everything
    for (int i = 0; i < 1500; i++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      kcyc(lfsr[0] | lfsr[1], lfsr[2] | lfsr[3], lfsr[AW+7:8]);
    end
    idle(4);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog %s actual=running expected=done", tag);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule